// File: doc/BRIEF.md
# DAC Register Readback Controller

This block is the register and readback engine behind a byte-level I2C slave front end for a four-channel DAC with 12-bit resolution. The front end handles SCL/SDA timing. It passes this block one-cycle event pulses: the start of a transfer addressed to the device with its direction, the end of the transfer (STOP), and each received data byte. It also pulls transmit bytes one at a time. The block groups received bytes into three-byte commands. Each command is a command byte (operation in the upper nibble, channel in the lower nibble), a data high byte and a data low byte. It executes each command into per-channel code registers, per-channel DAC registers and power-down bits.

Every read transfer returns a three-byte frame, then all-ones fill bytes. How the frame is built depends on the write transfer that came before it. A short write of one or two bytes, or a single full command, leaves the block in standard mode. In standard mode the read reports the register chosen by the request byte. A multi-command write (four bytes or more) arms a one-shot echo, and the next read returns the last executed command verbatim so the host can verify the interface. Once any read has consumed the echo, reads fall back to standard mode.

Top module: `dac_rb_ctrl`

## Requirements
- R1: A write transfer is split into triples counted from its first byte: byte 0 is the command byte, byte 1 is the high data byte and byte 2 is the low data byte. A command executes on its third byte. The 12-bit value is {high byte, low byte[7:4]}, and low byte[3:0] is ignored. Operation 0000 loads the code register of channel cmd[3:0]. Operations 0001, 0010 and 0011 load that channel's DAC register, which is visible on `dac_val[ch*12 +: 12]`.
- R2: A code or DAC write whose channel field is 4 or more changes no register.
- R3: Operation 0100 loads the power-down bits from the low byte: bit i controls channel i and appears on `pd_val[i]`.
- R4: In standard mode a read returns the request byte, then value[11:4], then {value[3:0], 0000}. The value is the code register for operation 0000 and the DAC register for 0001 to 0011. The request byte is the first byte of a one- or two-byte write, or the last executed command byte of a longer write.
- R5: A standard read with operation 0100 returns 0x00 as the high byte and {0000, pd[3:0]} as the low byte.
- R6: A standard read of any other operation, or with a channel field of 4 or more for operations 0000 to 0011, returns {00000, revision 010} as the high byte and {000000, ref_mode} as the low byte.
- R7: Every byte pulled after the third byte of a read frame is 0xFF.
- R8: A write transfer of four or more bytes arms the echo. The next read returns the last completed triple verbatim, including low byte[3:0]. Trailing bytes that do not complete a triple are discarded.
- R9: Any read consumes the echo, even a partial one. Later reads use standard mode with the last executed command byte as the request.
- R10: A write of exactly three bytes executes the command, clears any pending echo and selects standard mode.
- R11: A write can be ended by a STOP or a repeated start. STOP events with no transfer addressed to the device change nothing.
- R12: After reset all registers and power-down bits are 0, no echo is pending, the request byte is 0x00 and `tx_byte` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_evt | input | 1 | Pulse: start or repeated start addressed to this device |
| sel_rd | input | 1 | Direction with `sel_evt`: 1 = read |
| stop_evt | input | 1 | Pulse: STOP seen on the bus |
| rx_valid | input | 1 | Pulse: `rx_byte` holds a received data byte |
| rx_byte | input | 8 | Received data byte |
| tx_next | input | 1 | Pulse: current `tx_byte` was sent, advance to the next byte |
| tx_byte | output | 8 | Byte to transmit now |
| ref_mode | input | 2 | Reference mode reported by the identification frame |
| dac_val | output | 48 | DAC registers, channel i at bits [i*12 +: 12] |
| pd_val | output | 4 | Power-down bits, bit i for channel i |

## Verification
The bench builds the block with its defaults: four channels, 12-bit data and revision 010. With four channels, channel fields 4 to 15 fall outside the register file, so both the ignored-write path and the identification fallback on reads can be reached. With 12 bits, the four padding bits of the low byte are exposed. This lets the bench tell a verbatim echo (padding kept) from a standard readback of the same command (padding zeroed). The bench ends write transfers with both STOP and repeated start, inserts foreign STOP events, and reads partial frames to observe the one-shot echo.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] hi;
    logic [7:0] lo;
  } triple_t;

  function automatic logic is_dac_op(input logic [3:0] op);
    return (op == 4'h1) || (op == 4'h2) || (op == 4'h3);
  endfunction
endpackage

// File: rtl/dac_rb_regs.sv
module dac_rb_regs
  import dac_rb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    exec,
  input  triple_t                 ex,
  output logic [NCH-1:0][DW-1:0]  code_q,
  output logic [NCH-1:0][DW-1:0]  dac_q,
  output logic [NCH-1:0]          pd_q
);
  localparam int PAD = 16 - DW;

  logic [3:0]    op;
  logic [DW-1:0] wdata;

  assign op    = ex.cmd[7:4];
  assign wdata = DW'({ex.hi, ex.lo} >> PAD);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          hit;
    logic [DW-1:0] code_r, code_d, dac_r, dac_d;
    logic          pd_r, pd_d;

    assign hit = exec && (ex.cmd[3:0] == 4'(g));

    always_comb begin
      code_d = code_r;
      dac_d  = dac_r;
      pd_d   = pd_r;
      if (hit && op == 4'h0) code_d = wdata;
      if (hit && is_dac_op(op)) dac_d = wdata;
      if (exec && op == 4'h4) pd_d = ex.lo[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_r <= '0;
        dac_r  <= '0;
        pd_r   <= 1'b0;
      end else begin
        code_r <= code_d;
        dac_r  <= dac_d;
        pd_r   <= pd_d;
      end
    end

    assign code_q[g] = code_r;
    assign dac_q[g]  = dac_r;
    assign pd_q[g]   = pd_r;
  end

  AST_CH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 4'h0 || is_dac_op(op)) && 32'(ex.cmd[3:0]) >= NCH)
      |=> ($stable(code_q) && $stable(dac_q)));  // R2
endmodule

// File: rtl/dac_rb_wrtrack.sv
module dac_rb_wrtrack
  import dac_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_evt,
  input  logic       sel_rd,
  input  logic       stop_evt,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       exec,
  output triple_t    ex,
  output logic       eff_echo,
  output logic [7:0] eff_req,
  output triple_t    last_q
);
  logic       wr_act, wr_act_d;
  logic [1:0] pos, pos_d;
  logic [2:0] bcnt, bcnt_d;
  logic [7:0] cmd_q, cmd_d, hi_q, hi_d;
  triple_t    last_d;
  logic       echo_q, echo_d;
  logic [7:0] req_q;
  logic       wr_close, rd_open, byte_in, many;

  assign wr_close = wr_act && (stop_evt || sel_evt);
  assign rd_open  = sel_evt && sel_rd;
  assign byte_in  = wr_act && rx_valid;
  assign exec     = byte_in && (pos == 2'd2);
  assign ex       = '{cmd: cmd_q, hi: hi_q, lo: rx_byte};
  assign many     = (bcnt >= 3'd4);

  always_comb begin
    eff_echo = echo_q;
    eff_req  = req_q;
    if (wr_close && bcnt != 3'd0) begin
      eff_echo = many;
      eff_req  = (bcnt < 3'd3) ? cmd_q : last_q.cmd;
    end
  end

  always_comb begin
    wr_act_d = wr_act;
    pos_d    = pos;
    bcnt_d   = bcnt;
    cmd_d    = cmd_q;
    hi_d     = hi_q;
    last_d   = last_q;
    if (sel_evt) begin
      wr_act_d = !sel_rd;
      pos_d    = 2'd0;
      bcnt_d   = 3'd0;
    end else if (stop_evt) begin
      wr_act_d = 1'b0;
    end else if (byte_in) begin
      pos_d = (pos == 2'd2) ? 2'd0 : 2'(pos + 2'd1);
      if (!many) bcnt_d = 3'(bcnt + 3'd1);
      if (pos == 2'd0) cmd_d = rx_byte;
      if (pos == 2'd1) hi_d  = rx_byte;
      if (exec) last_d = ex;
    end
    echo_d = rd_open ? 1'b0 : eff_echo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act <= 1'b0;
      pos    <= 2'd0;
      bcnt   <= 3'd0;
      cmd_q  <= 8'h00;
      hi_q   <= 8'h00;
      last_q <= '0;
      echo_q <= 1'b0;
      req_q  <= 8'h00;
    end else begin
      wr_act <= wr_act_d;
      pos    <= pos_d;
      bcnt   <= bcnt_d;
      cmd_q  <= cmd_d;
      hi_q   <= hi_d;
      last_q <= last_d;
      echo_q <= echo_d;
      req_q  <= eff_req;
    end
  end

  AST_ECHO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |=> !echo_q);  // R9
  AST_ARM_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_close && many && !rd_open) |=> echo_q);  // R8
  AST_EXACT3_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_close && bcnt == 3'd3) |=> !echo_q);  // R10
endmodule

// File: rtl/dac_rb_rdframe.sv
module dac_rb_rdframe
  import dac_rb_pkg::*;
#(
  parameter int         NCH    = 4,
  parameter int         DW     = 12,
  parameter logic [2:0] REV_ID = 3'b010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_evt,
  input  logic                    sel_rd,
  input  logic                    stop_evt,
  input  logic                    tx_next,
  input  logic                    eff_echo,
  input  logic [7:0]              eff_req,
  input  triple_t                 last_q,
  input  logic [NCH-1:0][DW-1:0]  code_q,
  input  logic [NCH-1:0][DW-1:0]  dac_q,
  input  logic [NCH-1:0]          pd_q,
  input  logic [1:0]              ref_mode,
  output logic [7:0]              tx_byte
);
  localparam int PAD = 16 - DW;
  localparam int CW  = $clog2(NCH);

  logic          rd_act, rd_act_d, rd_open, ch_ok;
  logic [1:0]    idx, idx_d;
  logic [3:0]    op;
  logic [CW-1:0] sel;
  triple_t       frm, frm_d, std;

  assign rd_open = sel_evt && sel_rd;
  assign op      = eff_req[7:4];
  assign sel     = eff_req[CW-1:0];
  assign ch_ok   = 32'(eff_req[3:0]) < NCH;

  always_comb begin
    std = '{cmd: eff_req, hi: 8'h00, lo: 8'h00};
    if (op == 4'h0 && ch_ok)
      {std.hi, std.lo} = 16'(code_q[sel]) << PAD;
    else if (is_dac_op(op) && ch_ok)
      {std.hi, std.lo} = 16'(dac_q[sel]) << PAD;
    else if (op == 4'h4)
      std.lo = 8'(pd_q);
    else begin
      std.hi = {5'b00000, REV_ID};
      std.lo = {6'b000000, ref_mode};
    end
  end

  always_comb begin
    rd_act_d = rd_act;
    idx_d    = idx;
    frm_d    = frm;
    if (rd_open) begin
      rd_act_d = 1'b1;
      idx_d    = 2'd0;
      frm_d    = eff_echo ? last_q : std;
    end else if (stop_evt || sel_evt) begin
      rd_act_d = 1'b0;
    end else if (rd_act && tx_next && idx != 2'd3) begin
      idx_d = 2'(idx + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      idx    <= 2'd0;
      frm    <= '0;
    end else begin
      rd_act <= rd_act_d;
      idx    <= idx_d;
      frm    <= frm_d;
    end
  end

  always_comb begin
    tx_byte = FILL_BYTE;
    if (rd_act) begin
      case (idx)
        2'd0:    tx_byte = frm.cmd;
        2'd1:    tx_byte = frm.hi;
        2'd2:    tx_byte = frm.lo;
        default: tx_byte = FILL_BYTE;
      endcase
    end
  end

  AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |=> (rd_act && idx == 2'd0));  // R4
  AST_PD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_open && !eff_echo && op == 4'h4)
      |=> (frm.hi == 8'h00 && (frm.lo >> NCH) == 8'h00));  // R5
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && idx == 2'd3 && !rd_open) |=> (idx == 2'd3 || !rd_act));  // R7
endmodule

// File: rtl/dac_rb_ctrl.sv
module dac_rb_ctrl
  import dac_rb_pkg::*;
#(
  parameter int         NCH    = 4,
  parameter int         DW     = 12,
  parameter logic [2:0] REV_ID = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_evt,
  input  logic              sel_rd,
  input  logic              stop_evt,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_next,
  output logic [7:0]        tx_byte,
  input  logic [1:0]        ref_mode,
  output logic [NCH*DW-1:0] dac_val,
  output logic [NCH-1:0]    pd_val
);
  logic                   exec, eff_echo;
  logic [7:0]             eff_req;
  triple_t                ex, last_q;
  logic [NCH-1:0][DW-1:0] code_q, dac_q;
  logic [NCH-1:0]         pd_q;

  dac_rb_wrtrack u_wr (
    .clk(clk), .rst_n(rst_n), .sel_evt(sel_evt), .sel_rd(sel_rd),
    .stop_evt(stop_evt), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .exec(exec), .ex(ex), .eff_echo(eff_echo), .eff_req(eff_req),
    .last_q(last_q)
  );

  dac_rb_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .exec(exec), .ex(ex),
    .code_q(code_q), .dac_q(dac_q), .pd_q(pd_q)
  );

  dac_rb_rdframe #(.NCH(NCH), .DW(DW), .REV_ID(REV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel_evt(sel_evt), .sel_rd(sel_rd),
    .stop_evt(stop_evt), .tx_next(tx_next), .eff_echo(eff_echo),
    .eff_req(eff_req), .last_q(last_q), .code_q(code_q), .dac_q(dac_q),
    .pd_q(pd_q), .ref_mode(ref_mode), .tx_byte(tx_byte)
  );

  assign dac_val = dac_q;
  assign pd_val  = pd_q;
endmodule

// File: tb/sim_dac_rb_ctrl.sv
`timescale 1ns/1ps
module sim_dac_rb_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, sel_evt, sel_rd, stop_evt, rx_valid, tx_next;
  logic [7:0]  rx_byte, tx_byte;
  logic [1:0]  ref_mode;
  logic [47:0] dac_val;
  logic [3:0]  pd_val;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  got [0:3];

  always #2 clk = ~clk;

  dac_rb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_evt(sel_evt), .sel_rd(sel_rd),
    .stop_evt(stop_evt), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_next(tx_next), .tx_byte(tx_byte), .ref_mode(ref_mode),
    .dac_val(dac_val), .pd_val(pd_val)
  );

  // {cmd, hi, lo, expected readback hi, expected readback lo}
  localparam logic [39:0] VEC [0:5] = '{
    40'h02ABCD_ABC0,  // R1 R4 code ch2
    40'h11123F_1230,  // R1 R4 dac ch1
    40'h33FEDA_FED0,  // R1 R4 dac ch3
    40'h400005_0005,  // R3 R5 power-down
    40'h059990_0202,  // R2 R6 channel 5
    40'h901234_0202   // R6 unsupported op
  };

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel(input logic rd);
    sel_evt = 1'b1; sel_rd = rd;
    @(negedge clk);
    sel_evt = 1'b0; sel_rd = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic stop();
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
  endtask

  task automatic rd(input int n);
    sel(1'b1);
    for (int k = 0; k < n; k++) begin
      got[k] = tx_byte;
      tx_next = 1'b1;
      @(negedge clk);
      tx_next = 1'b0;
    end
  endtask

  task automatic chk_frame(input string tag, input logic [7:0] b0, b1, b2);
    chk({tag, " byte0"}, 48'(got[0]), 48'(b0));
    chk({tag, " byte1"}, 48'(got[1]), 48'(b1));
    chk({tag, " byte2"}, 48'(got[2]), 48'(b2));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_evt = 1'b0; sel_rd = 1'b0; stop_evt = 1'b0;
    rx_valid = 1'b0; rx_byte = 8'h00; tx_next = 1'b0; ref_mode = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 tx idle", 48'(tx_byte), 48'hFF);
    chk("R12 dac_val", dac_val, 48'h0);
    chk("R12 pd_val", 48'(pd_val), 48'h0);
    rd(4); stop();
    chk_frame("R12 read after reset", 8'h00, 8'h00, 8'h00);
    chk("R7 fill after reset", 48'(got[3]), 48'hFF);

    // table: three-byte write then standard read
    for (int i = 0; i < 6; i++) begin
      sel(1'b0);
      put(VEC[i][39:32]); put(VEC[i][31:24]); put(VEC[i][23:16]);
      stop();
      rd(4); stop();
      chk_frame($sformatf("R4/R5/R6 vector %0d", i), VEC[i][39:32], VEC[i][15:8], VEC[i][7:0]);
      chk($sformatf("R7 vector %0d fill", i), 48'(got[3]), 48'hFF);
    end
    chk("R1 dac ch1", 48'(dac_val[12 +: 12]), 48'h123);
    chk("R1 dac ch3", 48'(dac_val[36 +: 12]), 48'hFED);
    chk("R3 pd bits", 48'(pd_val), 48'h5);

    // R2 out-of-range dac write leaves all registers
    sel(1'b0); put(8'h17); put(8'hFF); put(8'hFF); stop();
    chk("R2 dac unchanged", dac_val, 48'hFED_000_123_000);

    // R4 R11 combined format: one-byte write, repeated start read
    sel(1'b0); put(8'h02);
    rd(4); stop();
    chk_frame("R4 R11 combined read", 8'h02, 8'hAB, 8'hC0);
    chk("R7 combined fill", 48'(got[3]), 48'hFF);

    // R4 two-byte write executes nothing
    sel(1'b0); put(8'h33); put(8'h00); stop();
    rd(3); stop();
    chk_frame("R4 two-byte request", 8'h33, 8'hFE, 8'hD0);

    // R8 R11 echo after multi-command write, with foreign STOP in between
    sel(1'b0);
    put(8'h10); put(8'h55); put(8'h5A); put(8'h23); put(8'h77); put(8'h7C);
    stop(); stop();
    rd(4); stop();
    chk_frame("R8 R11 echo", 8'h23, 8'h77, 8'h7C);
    chk("R7 echo fill", 48'(got[3]), 48'hFF);
    chk("R1 dac ch0", 48'(dac_val[0 +: 12]), 48'h555);
    chk("R1 dac ch3 low nibble dropped", 48'(dac_val[36 +: 12]), 48'h777);

    // R9 echo only once
    rd(3); stop();
    chk_frame("R9 second read standard", 8'h23, 8'h77, 8'h70);

    // R8 trailing partial triple, repeated start, partial read
    sel(1'b0); put(8'h31); put(8'h44); put(8'h4F); put(8'h02);
    rd(1); stop();
    chk("R8 partial echo byte0", 48'(got[0]), 48'h31);
    rd(3); stop();
    chk_frame("R9 after partial read", 8'h31, 8'h44, 8'h40);

    // R10 exact three-byte write clears armed echo
    sel(1'b0);
    put(8'h10); put(8'h01); put(8'h02); put(8'h20); put(8'h03); put(8'h04);
    stop();
    sel(1'b0); put(8'h00); put(8'h11); put(8'h22); stop();
    rd(3); stop();
    chk_frame("R10 exact three standard", 8'h00, 8'h11, 8'h20);

    summary();
    $finish;
  end
endmodule